// File: doc/BRIEF.md
# Byte ALU with Condition Flags

This block is an 8-bit arithmetic and logic stage that, in one step, computes a result and the next value of an eight-bit condition byte. It supports five operations: plain addition, addition that includes the incoming carry flag, bitwise AND, arithmetic shift right, and a 16-bit addition of a small unsigned constant to a register pair. A surrounding core supplies the operands, an operation code and the current condition byte. It writes the result back and keeps the returned condition byte.

The flags follow one fixed rule set. The sign flag is always negative XOR overflow. The half carry is the carry out of bit 3. After a shift, overflow is defined as negative XOR carry. Each operation leaves its own set of flags unchanged. Result and flags are registered, so they appear one clock after the request.

Top module: `alu8_core`

## Requirements
- R1: A request accepted with `in_valid` high on one clock edge shows its `result`, `status_out` and a high `out_valid` after that edge. Without a request, `out_valid` is low and `result` and `status_out` hold their values. Synchronous reset clears all three outputs to zero.
- R2: Condition byte layout: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 overflow (V), bit 4 sign (S), bit 5 half carry (H). Bits 7 and 6 are always copied from `status_in`.
- R3: Op code 0 (add): result = A+B modulo 256 in `result[7:0]`, with `result[15:8]` = 0. C is the carry out of bit 7 and H the carry out of bit 3. V is set when A and B have the same sign bit and the result sign differs.
- R4: Op code 1 (add with carry): as R3, but the incoming C from `status_in` is added as well, so it counts toward both C and H.
- R5: For op codes 0 to 3, Z is set exactly when `result[7:0]` is 0x00 and N equals `result[7]`. For every defined op code, S = N XOR V.
- R6: Op code 2 (AND): result = A AND B. V is cleared. C and H are copied from `status_in`.
- R7: Op code 3 (shift right): bit 7 of A is kept, the other bits move down one place, and old bit 0 of A goes into C. V = N XOR C, using the new values. H is copied from `status_in`.
- R8: Op code 4 (word add): result = pair + zero-extended 6-bit immediate modulo 65536. C is the carry out of bit 15, Z is set when all 16 bits are zero, N = `result[15]`, and V is set when the pair's bit 15 is 0 and the result's bit 15 is 1. H is copied from `status_in`.
- R9: Op codes 5, 6 and 7 give `result` = 0 and a `status_out` equal to `status_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| opnd_a | input | 8 | First byte operand |
| opnd_b | input | 8 | Second byte operand |
| pair | input | 16 | Register pair for the word add |
| imm | input | 6 | Unsigned constant for the word add |
| status_in | input | 8 | Current condition byte |
| out_valid | output | 1 | Result valid |
| result | output | 16 | Result (upper byte zero for byte operations) |
| status_out | output | 8 | Next condition byte |

## Verification
Two flag rules often act in the same cycle: the carry-out rule and the overflow rule. With add-with-carry, the incoming carry can also ripple through both the nibble boundary and the byte boundary. The bench provokes this with operands such as 0xFF + 0x00 + C, 0x7F + 0x00 + C and 0x80 + 0x80. For the shift, it uses 0x01 and 0x81, where carry and sign together decide V. A behavioural model built from integer arithmetic predicts each registered output one clock ahead, and every cycle is compared in full, including the cycles where the outputs should hold.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int STAT_W = 8;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_ADD  = 3'd0;
  localparam logic [OP_W-1:0] OP_ADC  = 3'd1;
  localparam logic [OP_W-1:0] OP_AND  = 3'd2;
  localparam logic [OP_W-1:0] OP_ASR  = 3'd3;
  localparam logic [OP_W-1:0] OP_ADDW = 3'd4;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_r,
  output logic [W-1:0] asr_r,
  output logic         asr_c
);
  always_comb begin
    and_r = a & b;
    asr_r = {a[W-1], a[W-1:1]};
    asr_c = a[0];
  end
endmodule

// File: rtl/alu8_statusgen.sv
module alu8_statusgen
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [STAT_W-1:0] st_in,
  input  logic [W-1:0]      add_r,
  input  logic              add_c,
  input  logic              add_v,
  input  logic              add_h,
  input  logic [W-1:0]      and_r,
  input  logic [W-1:0]      asr_r,
  input  logic              asr_c,
  input  logic [2*W-1:0]    wsum,
  input  logic              w_c,
  input  logic              w_v,
  output logic [STAT_W-1:0] st_out
);
  logic n_t, v_t;

  always_comb begin
    st_out = st_in;
    n_t = 1'b0;
    v_t = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        n_t = add_r[W-1];
        v_t = add_v;
        st_out[FL_C] = add_c;
        st_out[FL_Z] = (add_r == '0);
        st_out[FL_N] = n_t;
        st_out[FL_V] = v_t;
        st_out[FL_S] = n_t ^ v_t;
        st_out[FL_H] = add_h;
      end
      OP_AND: begin
        n_t = and_r[W-1];
        st_out[FL_Z] = (and_r == '0);
        st_out[FL_N] = n_t;
        st_out[FL_V] = 1'b0;
        st_out[FL_S] = n_t;
      end
      OP_ASR: begin
        n_t = asr_r[W-1];
        v_t = n_t ^ asr_c;
        st_out[FL_C] = asr_c;
        st_out[FL_Z] = (asr_r == '0);
        st_out[FL_N] = n_t;
        st_out[FL_V] = v_t;
        st_out[FL_S] = n_t ^ v_t;
      end
      OP_ADDW: begin
        n_t = wsum[2*W-1];
        v_t = w_v;
        st_out[FL_C] = w_c;
        st_out[FL_Z] = (wsum == '0);
        st_out[FL_N] = n_t;
        st_out[FL_V] = v_t;
        st_out[FL_S] = n_t ^ v_t;
      end
      default: st_out = st_in;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [2:0]            op,
  input  logic [DATA_W-1:0]     opnd_a,
  input  logic [DATA_W-1:0]     opnd_b,
  input  logic [2*DATA_W-1:0]   pair,
  input  logic [IMM_W-1:0]      imm,
  input  logic [7:0]            status_in,
  output logic                  out_valid,
  output logic [2*DATA_W-1:0]   result,
  output logic [7:0]            status_out
);
  localparam int WORD_W = 2 * DATA_W;
  localparam int HBIT   = DATA_W / 2;

  logic [DATA_W-1:0] add_r, and_r, asr_r;
  logic              add_c, add_v, add_h, asr_c, cin;
  logic [WORD_W-1:0] wsum, imm_ext;
  logic              w_c, w_v;
  logic [WORD_W-1:0] res_nxt;
  logic [7:0]        st_nxt;

  assign cin     = (op == OP_ADC) ? status_in[FL_C] : 1'b0;
  assign imm_ext = {{(WORD_W-IMM_W){1'b0}}, imm};
  // carry into bit HBIT recovered from the sum and operand bits
  assign add_h   = add_r[HBIT] ^ opnd_a[HBIT] ^ opnd_b[HBIT];

  alu8_adder #(.W(DATA_W)) u_add8 (
    .a(opnd_a), .b(opnd_b), .cin(cin),
    .sum(add_r), .cout(add_c), .ovf(add_v)
  );

  alu8_adder #(.W(WORD_W)) u_add16 (
    .a(pair), .b(imm_ext), .cin(1'b0),
    .sum(wsum), .cout(w_c), .ovf(w_v)
  );

  alu8_bitops #(.W(DATA_W)) u_bits (
    .a(opnd_a), .b(opnd_b),
    .and_r(and_r), .asr_r(asr_r), .asr_c(asr_c)
  );

  alu8_statusgen #(.W(DATA_W)) u_stat (
    .op(op), .st_in(status_in),
    .add_r(add_r), .add_c(add_c), .add_v(add_v), .add_h(add_h),
    .and_r(and_r), .asr_r(asr_r), .asr_c(asr_c),
    .wsum(wsum), .w_c(w_c), .w_v(w_v),
    .st_out(st_nxt)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_ADC: res_nxt = {{DATA_W{1'b0}}, add_r};
      OP_AND:         res_nxt = {{DATA_W{1'b0}}, and_r};
      OP_ASR:         res_nxt = {{DATA_W{1'b0}}, asr_r};
      OP_ADDW:        res_nxt = wsum;
      default:        res_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      status_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= res_nxt;
        status_out <= st_nxt;
      end
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [2:0]          op,
  input logic [DATA_W-1:0]   opnd_a,
  input logic [7:0]          status_in,
  input logic                out_valid,
  input logic [2*DATA_W-1:0] result,
  input logic [7:0]          status_out
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(status_out)));

  assert_upper_bits_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (status_out[7:6] == $past(status_in[7:6])));

  assert_sign_rule_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op <= OP_ADDW) |=> (status_out[FL_S] == (status_out[FL_N] ^ status_out[FL_V])));

  assert_and_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_AND) |=> (!status_out[FL_V]
      && status_out[FL_C] == $past(status_in[FL_C])
      && status_out[FL_H] == $past(status_in[FL_H])));

  assert_shift_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ASR) |=> (result[DATA_W-1] == $past(opnd_a[DATA_W-1])
      && status_out[FL_C] == $past(opnd_a[0])));

  assert_word_h_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ADDW) |=> (status_out[FL_H] == $past(status_in[FL_H])));
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opnd_a(opnd_a),
  .status_in(status_in), .out_valid(out_valid), .result(result),
  .status_out(status_out)
);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op;
  logic [7:0]  opnd_a, opnd_b, status_in;
  logic [15:0] pair;
  logic [5:0]  imm;
  logic        out_valid;
  logic [15:0] result;
  logic [7:0]  status_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic        exp_v;
  logic [15:0] exp_r;
  logic [7:0]  exp_s;
  string       exp_tag;

  always #10 clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .pair(pair), .imm(imm),
    .status_in(status_in), .out_valid(out_valid), .result(result),
    .status_out(status_out)
  );

  task automatic compare();
    compared++;
    if (out_valid !== exp_v || result !== exp_r || status_out !== exp_s) begin
      mismatched++;
      $display("FAIL %s: got v=%0b r=%h s=%b, expected v=%0b r=%h s=%b",
               exp_tag, out_valid, result, status_out, exp_v, exp_r, exp_s);
    end
  endtask

  // behavioural reference from the requirements
  task automatic model(input logic v, input int o, input int a, input int b,
                       input int p, input int k, input int st);
    int r, s, n, vv, c, sum;
    if (!v) begin
      exp_v = 0;
      exp_tag = "R1 hold";
      return;
    end
    exp_v = 1;
    s = st;
    r = 0;
    n = 0; vv = 0;
    case (o)
      0, 1: begin
        c = (o == 1) ? (st & 1) : 0;
        sum = a + b + c;
        r = sum % 256;
        n = (r >> 7) & 1;
        vv = (((a >> 7) == (b >> 7)) && ((r >> 7) != (a >> 7))) ? 1 : 0;
        s = (st & 8'hC0) | (sum >= 256 ? 1 : 0) | (r == 0 ? 2 : 0) | (n << 2)
          | (vv << 3) | ((n ^ vv) << 4) | ((((a % 16) + (b % 16) + c) >= 16) ? 32 : 0);
        exp_tag = (o == 1) ? "R4 adc" : "R3 add";
      end
      2: begin
        r = a & b;
        n = (r >> 7) & 1;
        s = (st & 8'hE1) | (r == 0 ? 2 : 0) | (n << 2) | (n << 4);
        exp_tag = "R6 and";
      end
      3: begin
        r = (a & 8'h80) | (a >> 1);
        c = a & 1;
        n = (r >> 7) & 1;
        vv = n ^ c;
        s = (st & 8'hE0) | c | (r == 0 ? 2 : 0) | (n << 2) | (vv << 3) | ((n ^ vv) << 4);
        exp_tag = "R7 asr";
      end
      4: begin
        sum = p + k;
        r = sum % 65536;
        n = (r >> 15) & 1;
        vv = (((p >> 15) & 1) == 0 && n == 1) ? 1 : 0;
        s = (st & 8'hE0) | (sum >= 65536 ? 1 : 0) | (r == 0 ? 2 : 0) | (n << 2)
          | (vv << 3) | ((n ^ vv) << 4);
        exp_tag = "R8 addw";
      end
      default: begin
        r = 0;
        s = st;
        exp_tag = "R9 undefined";
      end
    endcase
    exp_r = r[15:0];
    exp_s = s[7:0];
  endtask

  task automatic step(input logic v, input int o, input int a, input int b,
                      input int p, input int k, input int st);
    @(negedge clk);
    compare();
    in_valid = v; op = o[2:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
    pair = p[15:0]; imm = k[5:0]; status_in = st[7:0];
    model(v, o, a, b, p, k, st);
  endtask

  initial begin
    rst = 1; in_valid = 0; op = 0; opnd_a = 0; opnd_b = 0;
    pair = 0; imm = 0; status_in = 0;
    exp_v = 0; exp_r = 0; exp_s = 0; exp_tag = "R1 reset";
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();                      // R1 reset state
    rst = 0;
    // R3 add: 0x7F+0x01 -> 0x80, V N H; R2 upper bits kept
    step(1, 0, 8'h7F, 8'h01, 0, 0, 8'hC0);
    step(1, 0, 8'hFF, 8'h01, 0, 0, 8'h00);   // R3 C Z H together
    step(1, 0, 8'h80, 8'h80, 0, 0, 8'h40);   // R3 C and V together
    step(1, 1, 8'hFF, 8'h00, 0, 0, 8'h01);   // R4 carry-in ripples through
    step(1, 1, 8'h7F, 8'h00, 0, 0, 8'h01);   // R4 V from carry-in
    step(1, 1, 8'h0F, 8'h00, 0, 0, 8'h00);   // R4 no carry-in
    step(0, 0, 8'h12, 8'h34, 0, 0, 8'hFF);   // R1 idle holds
    step(0, 2, 8'hFF, 8'hFF, 0, 0, 8'h00);   // R1 idle holds
    step(1, 2, 8'hF0, 8'h0F, 0, 0, 8'h29);   // R6 Z, C H kept, V cleared
    step(1, 2, 8'hAA, 8'h8F, 0, 0, 8'h00);   // R6 N S
    step(1, 3, 8'h81, 0, 0, 0, 8'h20);       // R7 0xC0 C N, V=0
    step(1, 3, 8'h01, 0, 0, 0, 8'h00);       // R7 zero, C, V=1
    step(1, 3, 8'h40, 0, 0, 0, 8'hFF);       // R7 H kept
    step(1, 4, 0, 0, 16'hFFFF, 1, 8'h20);    // R8 C Z 16-bit
    step(1, 4, 0, 0, 16'h7FFF, 63, 8'h00);   // R8 V N
    step(1, 4, 0, 0, 16'h00FF, 1, 8'h00);    // R8 Z not set at 0x0100
    step(1, 5, 8'h11, 8'h22, 0, 0, 8'h5A);   // R9
    step(1, 7, 8'hFF, 8'hFF, 0, 0, 8'hA5);   // R9
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 8) != 0, $urandom % 8, $urandom % 256, $urandom % 256,
           $urandom % 65536, $urandom % 64, $urandom % 256);
    end
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule